// File: doc/BRIEF.md
# Interrupt Routing Table Controller

This block gathers 32 hardware interrupt lines and steers each of them to a set of hardware threads. Every source owns a two-word routing entry in a small register space. The first word is a destination mask with one bit per thread. The second word holds the controls and the vector number that the thread receives.

Each source line drives a pending latch. Sources 1 to 8 are timer lines and are edge-sensitive. Every other source, including the watchdog on source 0, is level-sensitive. Software clears pending state by writing a one-hot acknowledge word. For each thread, the controller presents a request and the vector of the lowest-numbered pending source that targets it.

A separate command register lets software send an inter-processor interrupt. The command names a processor and a thread on it, and may carry a non-maskable flag. The interrupt is delivered as a one-cycle pulse.

Top module: `irt_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every routing word reads zero and both `thr_req` and `ipi_req` are all zero.
- R2: Entry n (0 to 31) uses two word addresses. Its destination mask is at 0x40+n and its control word is at 0x80+n. Each returns exactly the last 32-bit value written to it. A read of 0x04, of 0x06 or of any unmapped address returns zero, and the read is combinational on `reg_addr`.
- R3: A source is forwarded only when bit 31 (valid) and bit 30 (enable) of its control word are both one. Bit 6 (local scheduling) is stored but has no effect on delivery.
- R4: A forwarded pending source raises `thr_req[t]` for every thread t whose destination mask bit t is set. `thr_vec[8t+7:8t]` then carries control-word bits 5:0, zero-extended. When `thr_req[t]` is low, that vector field is zero.
- R5: When several forwarded pending sources target the same thread, the lowest-numbered source supplies the vector.
- R6: Sources 1 to 8 become pending on the first clock edge that samples a rising input. They stay pending after the input falls, until they are acknowledged.
- R7: Every other source is pending one clock edge after its input goes high, and stops being pending one edge after its input goes low.
- R8: A write to 0x06 clears pending state for every source whose bit is one in the written word, and leaves the other sources untouched. An acknowledged edge source stays clear until a new rising edge. An acknowledged level source whose input is still high is clear for one cycle and pending again on the following edge.
- R9: A write to 0x04 gives, on the next cycle only, a one-hot `ipi_req` at bit (4 × bits 22:20 + bits 17:16). That same cycle `ipi_vec` equals bits 7:0 and `ipi_nmi` equals bit 8. In every other cycle `ipi_req` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_in | input | 32 | Hardware interrupt source lines |
| thr_req | output | 32 | Per-thread interrupt request |
| thr_vec | output | 256 | Per-thread vector, 8 bits per thread, thread 0 in the low byte |
| ipi_req | output | 32 | One-cycle one-hot inter-processor interrupt |
| ipi_vec | output | 8 | Vector of the inter-processor interrupt |
| ipi_nmi | output | 1 | Non-maskable flag of the inter-processor interrupt |

## Verification
Routing state is stored only in the entry words, so a corrupted entry reads back wrong through the register port at once. It also shows on `thr_req` or `thr_vec` the same cycle a source is pending. A wrong pending latch shows one edge after the input or acknowledge that should have moved it: a stuck edge latch survives an acknowledge, and a level latch fails to return the cycle after one. A bad command decode shows on `ipi_req` in the single cycle after the write, as a wrong bit or a pulse that lasts too long.

// File: rtl/irt_pkg.sv
// Package: shared register offsets and field positions of the routing controller.
// Assumes word addressing on a 9-bit register port.
package irt_pkg;
    localparam int unsigned ADDR_W      = 9;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned ENTRY_VEC_W = 6;
    localparam int unsigned OUT_VEC_W   = 8;

    localparam logic [ADDR_W-1:0] ADDR_IPI = 9'h004;
    localparam logic [ADDR_W-1:0] ADDR_ACK = 9'h006;
    localparam logic [ADDR_W-1:0] BASE_W0  = 9'h040;
    localparam logic [ADDR_W-1:0] BASE_W1  = 9'h080;

    localparam int unsigned BIT_VALID = 31;
    localparam int unsigned BIT_EN    = 30;
endpackage

// File: rtl/irt_table.sv
// Module: routing entry storage and read mux.
// Holds a destination mask word and a control word per source and exports the
// decoded routing fields. Assumes NUM_SRC <= 64 and NUM_THR <= 32.
module irt_table
    import irt_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_THR = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [WORD_W-1:0]                      wdata,
    output logic [WORD_W-1:0]                      rdata,
    output logic [NUM_SRC-1:0]                     route_on,
    output logic [NUM_SRC-1:0][ENTRY_VEC_W-1:0]    route_vec,
    output logic [NUM_SRC-1:0][NUM_THR-1:0]        route_mask
);
    logic [NUM_SRC-1:0][WORD_W-1:0] mask_q;
    logic [NUM_SRC-1:0][WORD_W-1:0] ctrl_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_entry
        localparam logic [ADDR_W-1:0] A0 = ADDR_W'(BASE_W0 + i);
        localparam logic [ADDR_W-1:0] A1 = ADDR_W'(BASE_W1 + i);

        // Store the destination mask word of this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)                 mask_q[i] <= '0;
            else if (we && addr == A0)  mask_q[i] <= wdata;
        end

        // Store the control word of this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)                 ctrl_q[i] <= '0;
            else if (we && addr == A1)  ctrl_q[i] <= wdata;
        end

        assign route_on[i]   = ctrl_q[i][BIT_VALID] & ctrl_q[i][BIT_EN];
        assign route_vec[i]  = ctrl_q[i][ENTRY_VEC_W-1:0];
        assign route_mask[i] = mask_q[i][NUM_THR-1:0];
    end

    // Return the addressed entry word; command registers and holes read zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr == ADDR_W'(BASE_W0 + i)) rdata = mask_q[i];
            if (addr == ADDR_W'(BASE_W1 + i)) rdata = ctrl_q[i];
        end
    end
endmodule

// File: rtl/irt_pending.sv
// Module: per-source pending latches.
// Sources EDGE_FIRST..EDGE_LAST latch on a rising input and hold until acknowledged;
// all others follow their input and drop for one cycle when acknowledged.
module irt_pending #(
    parameter int unsigned NUM_SRC    = 32,
    parameter int unsigned EDGE_FIRST = 1,
    parameter int unsigned EDGE_LAST  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i >= EDGE_FIRST && i <= EDGE_LAST) begin : g_edge
            logic prev_q;
            // Remember the previous input sample for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= src_in[i];
            end
            // Set on a rising edge (wins over acknowledge), clear on acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)                      pend[i] <= 1'b0;
                else if (src_in[i] && !prev_q)   pend[i] <= 1'b1;
                else if (ack[i])                 pend[i] <= 1'b0;
            end
        end else begin : g_level
            // Follow the input, masked for one cycle by an acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n) pend[i] <= 1'b0;
                else        pend[i] <= src_in[i] & ~ack[i];
            end
        end
    end
endmodule

// File: rtl/irt_arbiter.sv
// Module: per-thread selection of the lowest-numbered forwarded pending source.
// Purely combinational; assumes routing fields are stable register outputs.
module irt_arbiter
    import irt_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_THR = 32
) (
    input  logic [NUM_SRC-1:0]                  pend,
    input  logic [NUM_SRC-1:0]                  route_on,
    input  logic [NUM_SRC-1:0][ENTRY_VEC_W-1:0] route_vec,
    input  logic [NUM_SRC-1:0][NUM_THR-1:0]     route_mask,
    output logic [NUM_THR-1:0]                  thr_req,
    output logic [NUM_THR*OUT_VEC_W-1:0]        thr_vec
);
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic                 hit;
        logic [OUT_VEC_W-1:0] vec;
        // Scan from the top so the lowest matching source is written last.
        always_comb begin
            hit = 1'b0;
            vec = '0;
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (pend[s] && route_on[s] && route_mask[s][t]) begin
                    hit = 1'b1;
                    vec = OUT_VEC_W'(route_vec[s]);
                end
            end
        end
        assign thr_req[t]                     = hit;
        assign thr_vec[t*OUT_VEC_W +: OUT_VEC_W] = vec;
    end
endmodule

// File: rtl/irt_ipi.sv
// Module: inter-processor interrupt pulse generator.
// A command write produces a one-cycle one-hot request to thread {pid,tid}.
module irt_ipi
    import irt_pkg::*;
#(
    parameter int unsigned NUM_THR = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [2:0]           pid,
    input  logic [1:0]           tid,
    input  logic [OUT_VEC_W-1:0] vec_in,
    input  logic                 nmi_in,
    output logic [NUM_THR-1:0]   ipi_req,
    output logic [OUT_VEC_W-1:0] ipi_vec,
    output logic                 ipi_nmi
);
    logic [4:0] thr_idx;
    assign thr_idx = {pid, tid};

    // Register the decoded command for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            ipi_req <= '0;
            ipi_vec <= '0;
            ipi_nmi <= 1'b0;
        end else begin
            ipi_req <= NUM_THR'(1) << thr_idx;
            ipi_vec <= vec_in;
            ipi_nmi <= nmi_in;
        end
    end
endmodule

// File: rtl/irt_ctrl.sv
// Module: interrupt routing table controller top.
// Connects entry storage, pending latches, per-thread arbitration and the
// inter-processor command path. Assumes NUM_SRC = 32 so the acknowledge word
// maps one bit per source.
module irt_ctrl
    import irt_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 32,
    parameter int unsigned NUM_THR    = 32,
    parameter int unsigned EDGE_FIRST = 1,
    parameter int unsigned EDGE_LAST  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    input  logic [NUM_SRC-1:0]            src_in,
    output logic [NUM_THR-1:0]            thr_req,
    output logic [NUM_THR*OUT_VEC_W-1:0]  thr_vec,
    output logic [NUM_THR-1:0]            ipi_req,
    output logic [OUT_VEC_W-1:0]          ipi_vec,
    output logic                          ipi_nmi
);
    logic [NUM_SRC-1:0]                  route_on;
    logic [NUM_SRC-1:0][ENTRY_VEC_W-1:0] route_vec;
    logic [NUM_SRC-1:0][NUM_THR-1:0]     route_mask;
    logic [NUM_SRC-1:0]                  pend;
    logic [NUM_SRC-1:0]                  ack;
    logic                                ack_wr;
    logic                                ipi_wr;

    assign ack_wr = reg_we && (reg_addr == ADDR_ACK);
    assign ipi_wr = reg_we && (reg_addr == ADDR_IPI);
    assign ack    = reg_wdata[NUM_SRC-1:0] & {NUM_SRC{ack_wr}};

    irt_table #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_table (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .route_on(route_on),
        .route_vec(route_vec), .route_mask(route_mask)
    );

    irt_pending #(.NUM_SRC(NUM_SRC), .EDGE_FIRST(EDGE_FIRST), .EDGE_LAST(EDGE_LAST)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .ack(ack), .pend(pend)
    );

    irt_arbiter #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_arb (
        .pend(pend), .route_on(route_on), .route_vec(route_vec),
        .route_mask(route_mask), .thr_req(thr_req), .thr_vec(thr_vec)
    );

    irt_ipi #(.NUM_THR(NUM_THR)) u_ipi (
        .clk(clk), .rst_n(rst_n), .fire(ipi_wr),
        .pid(reg_wdata[22:20]), .tid(reg_wdata[17:16]),
        .vec_in(reg_wdata[7:0]), .nmi_in(reg_wdata[8]),
        .ipi_req(ipi_req), .ipi_vec(ipi_vec), .ipi_nmi(ipi_nmi)
    );
endmodule

// File: rtl/irt_ctrl_chk.sv
// Module: property checker for the routing controller, bound to irt_ctrl.
// Observes ports only.
module irt_ctrl_chk
    import irt_pkg::*;
#(
    parameter int unsigned NUM_THR = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [WORD_W-1:0]    reg_rdata,
    input logic [NUM_THR-1:0]   thr_req,
    input logic [OUT_VEC_W-1:0] thr_vec0,
    input logic [NUM_THR-1:0]   ipi_req
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (thr_req == '0 && ipi_req == '0)); // R1
    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_ACK || reg_addr == ADDR_IPI) |-> reg_rdata == '0); // R2
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_req[0] |-> thr_vec0 == '0); // R4
    AST_IPI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ipi_req)); // R9
    AST_IPI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_req != '0) |-> $past(reg_we && reg_addr == ADDR_IPI)); // R9
    AST_IPI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_req != '0 && !(reg_we && reg_addr == ADDR_IPI)) |=> ipi_req == '0); // R9
endmodule

bind irt_ctrl irt_ctrl_chk #(.NUM_THR(NUM_THR)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .thr_req(thr_req), .thr_vec0(thr_vec[7:0]),
    .ipi_req(ipi_req)
);

// File: tb/sim_irt_ctrl.sv
module sim_irt_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [8:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [31:0]  src_in = '0;
    logic [31:0]  thr_req;
    logic [255:0] thr_vec;
    logic [31:0]  ipi_req;
    logic [7:0]   ipi_vec;
    logic         ipi_nmi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .thr_req(thr_req), .thr_vec(thr_vec), .ipi_req(ipi_req),
        .ipi_vec(ipi_vec), .ipi_nmi(ipi_nmi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] vec_of(input int t);
        return thr_vec[t*8 +: 8];
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 thr_req", thr_req, 32'h0);
        check("R1 ipi_req", ipi_req, 32'h0);
        for (int n = 0; n < 32; n += 7) begin
            rd(9'(9'h40 + n), d); check("R1 mask word", d, 32'h0);
            rd(9'(9'h80 + n), d); check("R1 ctrl word", d, 32'h0);
        end

        // R2: readback of every entry word, command registers read zero
        for (int n = 0; n < 32; n++) begin
            wr(9'(9'h40 + n), 32'h1357_9BDF ^ (32'(n) * 32'h0101_0101));
            wr(9'(9'h80 + n), 32'hC000_0040 | 32'(n) | (32'(n) << 12));
        end
        for (int n = 0; n < 32; n++) begin
            rd(9'(9'h40 + n), d);
            check("R2 mask readback", d, 32'h1357_9BDF ^ (32'(n) * 32'h0101_0101));
            rd(9'(9'h80 + n), d);
            check("R2 ctrl readback", d, 32'hC000_0040 | 32'(n) | (32'(n) << 12));
        end
        rd(9'h004, d); check("R2 ipi reads zero", d, 32'h0);
        rd(9'h006, d); check("R2 ack reads zero", d, 32'h0);
        rd(9'h0C0, d); check("R2 hole reads zero", d, 32'h0);
        // Retarget every source to thread 0 with vector n+1 for the R5 sweep
        for (int n = 0; n < 32; n++) begin
            wr(9'(9'h40 + n), 32'h1);
            wr(9'(9'h80 + n), 32'hC000_0000 | 32'(n + 1));
        end

        // R5/R6/R7: lowest forwarded pending source wins, over many patterns
        for (int k = 0; k < 40; k++) begin
            logic [31:0] pat;
            int low;
            if (k < 32) pat = 32'h1 << k;
            else        pat = 32'hFFFF_FFFF << (k - 32) * 3 | 32'h8000_0000;
            low = 0;
            for (int b = 31; b >= 0; b--) if (pat[b]) low = b;
            @(negedge clk); src_in = '0;
            wr(9'h006, 32'hFFFF_FFFF);
            src_in = pat;
            @(negedge clk);
            check("R5 req thread0", {31'h0, thr_req[0]}, 32'h1);
            check("R5 winner vec", {24'h0, vec_of(0)}, 32'(low + 1));
            check("R4 other thread idle", {31'h0, thr_req[1]}, 32'h0);
        end
        @(negedge clk); src_in = '0;
        wr(9'h006, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) wr(9'(9'h80 + n), 32'h0);

        // R3: valid and enable both required, local bit irrelevant
        wr(9'h054, 32'h1 << 5);
        src_in = 32'h1 << 20;
        for (int c = 0; c < 8; c++) begin
            wr(9'h094, (32'(c & 1) << 31) | (32'((c >> 1) & 1) << 30) | (32'((c >> 2) & 1) << 6) | 32'h11);
            @(negedge clk);
            check("R3 forward gate", {31'h0, thr_req[5]}, 32'((c & 3) == 3));
            check("R3 vec", {24'h0, vec_of(5)}, ((c & 3) == 3) ? 32'h11 : 32'h0);
        end
        wr(9'h094, 32'h0);
        src_in = '0;

        // R4: fan-out to every masked thread
        wr(9'h04C, 32'hA5A5_0F0F);
        wr(9'h08C, 32'hC000_002B);
        src_in = 32'h1 << 12;
        @(negedge clk);
        for (int t = 0; t < 32; t++) begin
            logic m;
            m = (32'hA5A5_0F0F >> t) & 1;
            check("R4 fanout req", {31'h0, thr_req[t]}, 32'(m));
            check("R4 fanout vec", {24'h0, vec_of(t)}, m ? 32'h2B : 32'h0);
        end
        src_in = '0;
        wr(9'h08C, 32'h0);

        // R6/R8: edge source 3 to thread 7
        wr(9'h043, 32'h1 << 7);
        wr(9'h083, 32'hC000_0003);
        src_in[3] = 1'b1;
        @(negedge clk);
        check("R6 edge latched", {31'h0, thr_req[7]}, 32'h1);
        src_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 edge held after input low", {31'h0, thr_req[7]}, 32'h1);
        wr(9'h006, 32'h1 << 3);
        check("R8 edge cleared by ack", {31'h0, thr_req[7]}, 32'h0);
        src_in[3] = 1'b1;
        @(negedge clk);
        check("R6 new edge relatches", {31'h0, thr_req[7]}, 32'h1);
        wr(9'h006, 32'h1 << 3);
        repeat (2) @(negedge clk);
        check("R8 edge stays clear with input high", {31'h0, thr_req[7]}, 32'h0);
        src_in[3] = 1'b0;

        // R7/R8: level source 10 to thread 9
        wr(9'h04A, 32'h1 << 9);
        wr(9'h08A, 32'hC000_000A);
        src_in[10] = 1'b1;
        @(negedge clk);
        check("R7 level pending", {31'h0, thr_req[9]}, 32'h1);
        src_in[10] = 1'b0;
        @(negedge clk);
        check("R7 level drops", {31'h0, thr_req[9]}, 32'h0);
        src_in[10] = 1'b1;
        @(negedge clk);
        wr(9'h006, ~(32'h1 << 10));
        check("R8 other ack bits ignored", {31'h0, thr_req[9]}, 32'h1);
        wr(9'h006, 32'h1 << 10);
        check("R8 level cleared one cycle", {31'h0, thr_req[9]}, 32'h0);
        @(negedge clk);
        check("R8 level reasserts", {31'h0, thr_req[9]}, 32'h1);
        src_in = '0;

        // R9: inter-processor interrupt sweep over all threads
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 4; t++) begin
                logic [7:0] v;
                logic nm;
                v = 8'((p * 32 + t * 7 + 5) & 255);
                nm = 1'((p + t) & 1);
                wr(9'h004, (32'(p) << 20) | (32'(t) << 16) | (32'(nm) << 8) | 32'(v));
                check("R9 ipi target", ipi_req, 32'h1 << (p * 4 + t));
                check("R9 ipi vec", {24'h0, ipi_vec}, {24'h0, v});
                check("R9 ipi nmi", {31'h0, ipi_nmi}, {31'h0, nm});
                @(negedge clk);
                check("R9 ipi single cycle", ipi_req, 32'h0);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule